// File: doc/BRIEF.md
# Priority-Ordered Thread Resume Queue with Line Prefetch

This block sits beside the instruction fetch path of a processor that runs cooperative threads in lock-step ticks. It holds, sorted by a small priority index, the code address at which each suspended thread will continue. The entry at the head is always the thread that runs next. Insertions carry their own priority index. Entries with equal index keep the order in which they arrived.

Next to the queue sits a one-line instruction buffer. The block fills it from main memory with the line that holds the head entry's resume address. When the processor switches threads, it then finds the first instructions of the next thread already on chip. A switch therefore costs no more than running on into an already prefetched sequential line.

Runtime code drives the block at three kinds of point:
- At a thread spawn, it pushes one address per child and then requests a fill.
- At an end of tick, it pushes the current thread's resume point and requests a fill.
- At a thread kill, it only requests a fill.

Every pop, which marks a context switch, also starts a refill from the new head.

Top module: `tq_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), `q_overflow`=0, `mem_req_valid`=0, and the fetch response outputs `cpu_rvalid`, `cpu_wait` and `cpu_miss` are all 0.
- R2: `head_addr` always shows the stored entry with the numerically lowest priority index (0 runs first). Entries with equal index leave the queue in the order they were pushed.
- R3: `q_full` is 1 exactly when DEPTH entries are stored, and `q_empty` is 1 exactly when none are stored. Both change at the clock edge that takes the push or pop.
- R4: A push while the queue is full and no pop is given in the same cycle is dropped. The stored entries stay as they were. `q_overflow` becomes 1 and stays 1 until reset.
- R5: A pop and a push in the same cycle act as the pop first, then the push into the freed slot, so a full queue accepts the push without overflow. A pop on an empty queue changes nothing in the queue.
- R6: A pop or a `fill_cmd` sampled at edge N sets a pending fill. If no fill is in progress, then at edge N+1 `mem_req_valid` rises for exactly one cycle, with `mem_req_line` = `head_addr >> log2(LINE_WORDS)`. If a fill is in progress, the request waits until that fill has finished.
- R7: If the queue is empty when a pending fill would start, no memory request is made and the buffer is invalidated, so every later fetch answers `cpu_miss`.
- R8: The fill stores the line's words in the order memory returns them, word 0 first, one per `mem_rsp_valid`. A fetch (`cpu_req` at edge N) whose address lies in the buffered line and whose word has arrived answers `cpu_rvalid`=1 with the word in `cpu_rdata` after edge N.
- R9: A fetch inside the buffered line whose word has not yet arrived answers `cpu_wait`=1 and never `cpu_rvalid`. At most one of `cpu_rvalid`, `cpu_wait` and `cpu_miss` is 1 in any cycle.
- R10: A fetch outside the buffered line answers `cpu_miss`=1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Insert a resume entry this cycle |
| push_addr | input | AW | Word address where the thread resumes |
| push_prio | input | PRIO_W | Priority index of the thread, 0 is highest |
| pop | input | 1 | Context switch: remove the head entry and refill |
| fill_cmd | input | 1 | Request a buffer refill from the current head |
| mem_req_valid | output | 1 | One-cycle line read request to main memory |
| mem_req_line | output | AW-log2(LINE_WORDS) | Line number requested |
| mem_rsp_valid | input | 1 | One line word returned this cycle |
| mem_rsp_data | input | DW | Returned word, in ascending word order |
| cpu_req | input | 1 | Processor instruction fetch |
| cpu_addr | input | AW | Fetch word address |
| cpu_rvalid | output | 1 | Previous fetch hit a filled word |
| cpu_wait | output | 1 | Previous fetch hit a word still being filled |
| cpu_miss | output | 1 | Previous fetch is outside the buffered line |
| cpu_rdata | output | DW | Instruction word for a hit |
| head_addr | output | AW | Resume address of the next thread |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| q_overflow | output | 1 | Sticky: a push was dropped because the queue was full |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a pop and a push. The bench provokes it on a full queue, with the pushed entry outranking every stored one. It judges the result from the flags, from the sticky overflow bit, and from the exact order in which entries then leave the head. The second pair is a processor fetch and an unfinished fill. The bench slows memory, pops, and fetches the last word of the new head line at once. The first answer must be a wait, and the bench keeps re-fetching until the word arrives and matches the value computed from its address.

// File: rtl/tq_pkg.sv
package tq_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_e;

endpackage

// File: rtl/tq_order.sv
module tq_order #(
  parameter int AW     = 16,
  parameter int PRIO_W = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [AW-1:0]     push_addr,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [AW-1:0]     head_addr,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [AW-1:0]     addr;
  } slot_t;

  slot_t          q  [DEPTH];
  slot_t          qp [DEPTH];
  slot_t          qn [DEPTH];
  slot_t          ins;
  logic [CW-1:0]  cnt, cnt_p, cnt_n, pos;
  logic           do_pop, accept;

  assign do_pop = pop && (cnt != '0);
  assign cnt_p  = cnt - CW'(do_pop);
  assign accept = push_valid && (cnt_p != CW'(DEPTH));
  assign cnt_n  = cnt_p + CW'(accept);
  assign ins    = '{prio: push_prio, addr: push_addr};

  // slot index of the new entry: after every stored entry of equal or better rank
  always_comb begin
    pos = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if ((CW'(j) < cnt_p) && (qp[j].prio <= push_prio)) pos = pos + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      assign qp[i] = do_pop ? '0 : q[i];
    end else begin : g_body
      assign qp[i] = do_pop ? q[i+1] : q[i];
    end
    if (i == 0) begin : g_head
      assign qn[i] = (accept && pos == '0) ? ins : qp[i];
    end else begin : g_rest
      assign qn[i] = !accept           ? qp[i]   :
                     (CW'(i) < pos)    ? qp[i]   :
                     (CW'(i) == pos)   ? ins     : qp[i-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) q[i] <= qn[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      overflow <= overflow | (push_valid & ~accept);
    end
  end

  assign head_addr = q[0].addr;
  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);

endmodule

// File: rtl/tq_linebuf.sv
module tq_linebuf
  import tq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4,
  localparam int OW  = $clog2(LINE_WORDS),
  localparam int LAW = AW - OW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           invalidate,
  input  logic [LAW-1:0] start_line,
  output logic           busy,
  output logic           mem_req_valid,
  output logic [LAW-1:0] mem_req_line,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  input  logic           cpu_req,
  input  logic [AW-1:0]  cpu_addr,
  output logic           cpu_rvalid,
  output logic           cpu_wait,
  output logic           cpu_miss,
  output logic [DW-1:0]  cpu_rdata
);
  logic [DW-1:0]         words [LINE_WORDS];
  logic [LINE_WORDS-1:0] wvld;
  logic [LAW-1:0]        tag;
  logic                  tag_ok;
  fill_st_e              st;
  logic [OW-1:0]         wcnt;
  logic [OW-1:0]         rd_idx;
  logic                  hit, take;

  assign rd_idx = cpu_addr[OW-1:0];
  assign hit    = tag_ok && (cpu_addr[AW-1:OW] == tag);
  assign take   = (st == FS_FILL) && mem_rsp_valid;
  assign busy   = (st == FS_FILL);

  // storage array: plain write port and registered read port
  always_ff @(posedge clk) begin
    if (take) words[wcnt] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    cpu_rdata <= words[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= FS_IDLE;
      wvld          <= '0;
      tag           <= '0;
      tag_ok        <= 1'b0;
      wcnt          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      cpu_rvalid    <= 1'b0;
      cpu_wait      <= 1'b0;
      cpu_miss      <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      if (start) begin
        st            <= FS_FILL;
        tag           <= start_line;
        tag_ok        <= 1'b1;
        wvld          <= '0;
        wcnt          <= '0;
        mem_req_valid <= 1'b1;
        mem_req_line  <= start_line;
      end else if (invalidate) begin
        tag_ok <= 1'b0;
        wvld   <= '0;
      end else if (take) begin
        wvld[wcnt] <= 1'b1;
        wcnt       <= wcnt + 1'b1;
        if (wcnt == OW'(LINE_WORDS - 1)) st <= FS_IDLE;
      end
      cpu_rvalid <= cpu_req &&  hit &&  wvld[rd_idx];
      cpu_wait   <= cpu_req &&  hit && !wvld[rd_idx];
      cpu_miss   <= cpu_req && !hit;
    end
  end

endmodule

// File: rtl/tq_prefetch_queue.sv
module tq_prefetch_queue #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int PRIO_W     = 2,
  parameter int DEPTH      = 4,
  parameter int LINE_WORDS = 4,
  localparam int OW  = $clog2(LINE_WORDS),
  localparam int LAW = AW - OW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [AW-1:0]     push_addr,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  input  logic              fill_cmd,
  output logic              mem_req_valid,
  output logic [LAW-1:0]    mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              cpu_req,
  input  logic [AW-1:0]     cpu_addr,
  output logic              cpu_rvalid,
  output logic              cpu_wait,
  output logic              cpu_miss,
  output logic [DW-1:0]     cpu_rdata,
  output logic [AW-1:0]     head_addr,
  output logic              q_full,
  output logic              q_empty,
  output logic              q_overflow
);
  logic fill_pend, launch, busy;

  tq_order #(.AW(AW), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_order (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_addr  (push_addr),
    .push_prio  (push_prio),
    .pop        (pop),
    .head_addr  (head_addr),
    .full       (q_full),
    .empty      (q_empty),
    .overflow   (q_overflow)
  );

  // a refill waits until the queue has settled and any running fill is done
  assign launch = fill_pend && !busy;

  always_ff @(posedge clk) begin
    if (rst) fill_pend <= 1'b0;
    else     fill_pend <= pop | fill_cmd | (fill_pend & ~launch);
  end

  tq_linebuf #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk           (clk),
    .rst           (rst),
    .start         (launch && !q_empty),
    .invalidate    (launch && q_empty),
    .start_line    (head_addr[AW-1:OW]),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_line  (mem_req_line),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .cpu_req       (cpu_req),
    .cpu_addr      (cpu_addr),
    .cpu_rvalid    (cpu_rvalid),
    .cpu_wait      (cpu_wait),
    .cpu_miss      (cpu_miss),
    .cpu_rdata     (cpu_rdata)
  );

endmodule

// File: rtl/tq_prefetch_queue_chk.sv
module tq_prefetch_queue_chk (
  input logic clk,
  input logic rst,
  input logic push_valid,
  input logic pop,
  input logic cpu_req,
  input logic mem_req_valid,
  input logic cpu_rvalid,
  input logic cpu_wait,
  input logic cpu_miss,
  input logic q_full,
  input logic q_empty,
  input logic q_overflow
);
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));

  assert_overflow_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    q_overflow |=> q_overflow);

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    (q_full && push_valid && !pop) |=> (q_full && q_overflow));

  assert_swap_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (q_full && push_valid && pop && !q_overflow) |=> (q_full && !q_overflow));

  assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_one_answer_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rvalid, cpu_wait, cpu_miss}));

  assert_answer_needs_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvalid || cpu_wait || cpu_miss) |-> $past(cpu_req));

endmodule

bind tq_prefetch_queue tq_prefetch_queue_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .push_valid    (push_valid),
  .pop           (pop),
  .cpu_req       (cpu_req),
  .mem_req_valid (mem_req_valid),
  .cpu_rvalid    (cpu_rvalid),
  .cpu_wait      (cpu_wait),
  .cpu_miss      (cpu_miss),
  .q_full        (q_full),
  .q_empty       (q_empty),
  .q_overflow    (q_overflow)
);

// File: tb/sim_tq_prefetch_queue.sv
`timescale 1ns/1ps
module sim_tq_prefetch_queue;
  localparam int AW = 16, DW = 32, PW = 2, DEPTH = 4, LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_valid = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [PW-1:0] push_prio = '0;
  logic          pop = 1'b0, fill_cmd = 1'b0;
  logic          mem_req_valid;
  logic [AW-3:0] mem_req_line;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rvalid, cpu_wait, cpu_miss;
  logic [DW-1:0] cpu_rdata;
  logic [AW-1:0] head_addr;
  logic          q_full, q_empty, q_overflow;

  int checks = 0, errors = 0, reqs = 0, mlat = 2;
  bit finished = 0;

  always #10 clk = ~clk;

  tq_prefetch_queue #(.AW(AW), .DW(DW), .PRIO_W(PW), .DEPTH(DEPTH), .LINE_WORDS(LW)) u0 (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_addr(push_addr),
    .push_prio(push_prio), .pop(pop), .fill_cmd(fill_cmd),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rvalid(cpu_rvalid),
    .cpu_wait(cpu_wait), .cpu_miss(cpu_miss), .cpu_rdata(cpu_rdata),
    .head_addr(head_addr), .q_full(q_full), .q_empty(q_empty), .q_overflow(q_overflow));

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  // main memory model: answers each line request after mlat idle cycles, one word per cycle
  bit            mact = 0;
  int            mdel = 0, mword = 0;
  logic [AW-3:0] mline = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst) begin
      mact = 0;
    end else if (mem_req_valid) begin
      reqs++;
      mline = mem_req_line; mdel = mlat; mword = 0; mact = 1;
    end else if (mact) begin
      if (mdel > 0) mdel--;
      else begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = word_of({mline, 2'(mword)});
        mword++;
        if (mword == LW) mact = 0;
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (3) tick(); rst = 1'b0; tick();
  endtask

  task automatic do_push(input logic [AW-1:0] a, input logic [PW-1:0] p);
    push_valid = 1'b1; push_addr = a; push_prio = p; tick(); push_valid = 1'b0;
  endtask

  task automatic do_pop(); pop = 1'b1; tick(); pop = 1'b0; endtask
  task automatic do_fill(); fill_cmd = 1'b1; tick(); fill_cmd = 1'b0; endtask

  task automatic fetch(input logic [AW-1:0] a);
    cpu_req = 1'b1; cpu_addr = a; tick(); cpu_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] adr [DEPTH];
    logic [PW-1:0] pri [DEPTH];
    logic [AW-1:0] exp_q [DEPTH];
    int n, r0, waits;
    bit got;

    do_reset();
    // R1 reset state
    chk(q_empty && !q_full, "R1 flags", {q_full, q_empty}, 2'b01);
    chk(!q_overflow && !mem_req_valid, "R1 overflow/req", {q_overflow, mem_req_valid}, 0);
    chk(!cpu_rvalid && !cpu_wait && !cpu_miss, "R1 fetch", {cpu_rvalid, cpu_wait, cpu_miss}, 0);

    // exhaustive sweep of priority patterns for a full queue (R2, R3)
    for (int pat = 0; pat < 256; pat++) begin
      for (int k = 0; k < DEPTH; k++) begin
        pri[k] = PW'(pat >> (2 * k));
        adr[k] = AW'(16'h1000 + pat * 64 + k * 16);
        do_push(adr[k], pri[k]);
        chk(q_full == (k == DEPTH - 1), "R3 full", q_full, k == DEPTH - 1);
      end
      n = 0;
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < DEPTH; k++)
          if (pri[k] == PW'(p)) begin exp_q[n] = adr[k]; n++; end
      for (int k = 0; k < DEPTH; k++) begin
        chk(head_addr == exp_q[k], "R2 order", head_addr, exp_q[k]);
        do_pop();
      end
      chk(q_empty && !q_full, "R3 empty", {q_full, q_empty}, 2'b01);
    end
    repeat (12) tick();

    // R4 dropped push on full queue
    for (int k = 0; k < DEPTH; k++) do_push(AW'(16'hB000 + k * 16), 2'd1);
    chk(!q_overflow, "R4 no overflow yet", q_overflow, 0);
    do_push(16'h7770, 2'd0);
    chk(q_overflow && q_full, "R4 overflow set", {q_overflow, q_full}, 2'b11);
    chk(head_addr == 16'hB000, "R4 contents kept", head_addr, 16'hB000);

    // R5 push and pop together on a full queue
    push_valid = 1'b1; push_addr = 16'h8000; push_prio = 2'd0; pop = 1'b1;
    tick(); push_valid = 1'b0; pop = 1'b0;
    chk(q_full, "R5 still full", q_full, 1);
    exp_q[0] = 16'h8000; exp_q[1] = 16'hB010; exp_q[2] = 16'hB020; exp_q[3] = 16'hB030;
    for (int k = 0; k < DEPTH; k++) begin
      chk(head_addr == exp_q[k], "R5 order", head_addr, exp_q[k]);
      do_pop();
    end
    do_pop();
    chk(q_empty && !q_full, "R5 pop on empty", {q_full, q_empty}, 2'b01);
    chk(q_overflow, "R4 sticky", q_overflow, 1);
    repeat (12) tick();

    // prefetch path
    do_reset();
    mlat = 2;
    do_push(16'h0240, 2'd2);
    do_push(16'h0310, 2'd1);
    chk(head_addr == 16'h0310, "R2 head", head_addr, 16'h0310);
    do_fill();
    chk(!mem_req_valid, "R6 no request at trigger edge", mem_req_valid, 0);
    tick();
    chk(mem_req_valid && mem_req_line == 14'h00C4, "R6 request line",
        {mem_req_valid, mem_req_line}, {1'b1, 14'h00C4});
    tick();
    chk(!mem_req_valid, "R6 single pulse", mem_req_valid, 0);
    repeat (10) tick();
    for (int w = 0; w < LW; w++) begin
      fetch(AW'(16'h0310 + w));
      chk(cpu_rvalid && cpu_rdata == word_of(AW'(16'h0310 + w)), "R8 hit data",
          cpu_rdata, word_of(AW'(16'h0310 + w)));
    end
    fetch(16'h0241);
    chk(cpu_miss && !cpu_rvalid, "R10 miss", {cpu_miss, cpu_rvalid}, 2'b10);
    do_pop();
    chk(head_addr == 16'h0240, "R2 next head", head_addr, 16'h0240);
    repeat (12) tick();
    fetch(16'h0241);
    chk(cpu_rvalid && cpu_rdata == word_of(16'h0241), "R8 refill on pop", cpu_rdata, word_of(16'h0241));
    r0 = reqs;
    do_pop();
    repeat (12) tick();
    chk(reqs == r0, "R7 no request on empty", reqs, r0);
    fetch(16'h0241);
    chk(cpu_miss, "R7 buffer invalidated", cpu_miss, 1);

    // R9 fetch racing an unfinished fill
    mlat = 2;
    do_push(16'h0500, 2'd0);
    do_push(16'h0600, 2'd3);
    do_fill();
    repeat (15) tick();
    mlat = 12;
    do_pop();
    tick();
    fetch(16'h0603);
    chk(cpu_wait && !cpu_rvalid, "R9 wait before word", {cpu_wait, cpu_rvalid}, 2'b10);
    got = 0; waits = 0;
    for (int t = 0; t < 40 && !got; t++) begin
      fetch(16'h0603);
      if (cpu_rvalid) got = 1;
      else if (cpu_wait) waits++;
    end
    chk(got && cpu_rdata == word_of(16'h0603), "R9 data after wait", cpu_rdata, word_of(16'h0603));
    chk(waits > 0, "R9 waited more than once", waits, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule